// File: doc/BRIEF.md
# Bit scan and count unit

This block is a single-stage execution unit that finds set bits in an operand. It serves four operations on one datapath. A forward scan gives the index of the lowest set bit. A reverse scan gives the index of the highest set bit. A trailing-zero count and a leading-zero count give the number of clear bits below or above the first set bit.

An operand arrives with a size code, a direction bit, a repeat-prefix flag and two feature enables. The block first zero-extends the operand from the chosen width. It then decides between count mode and scan mode. The two modes differ in three ways: what they return for an all-zero operand, which flags they define, and whether the zero flag follows the operand or the result.

Results come out one clock after the request. A no-write strobe marks the case where the destination register must keep its old value. A surrounding pipeline uses the unit by presenting an operand with a valid strobe and consuming the result, flags, flag-defined mask and no-write strobe on the following cycle.

Top module: `bitsearch_unit`

## Requirements
- R1: While reset is high and in the cycle after it, out_valid is 0 and result, carry_flag, zero_flag, flag_def and no_write are all 0.
- R2: size_code 0 selects a 16-bit operand, 1 selects 32 bits, and 2 or 3 select 64 bits. Operand bits at or above the selected width have no effect on any output.
- R3: Count mode is used when rep_prefix is 1 and the enable for the requested direction is set: lead_en for reverse=1, trail_en for reverse=0. In every other case scan mode is used.
- R4: In count mode with reverse=1, result is the number of clear bits above the highest set bit within the operand width. An all-zero operand returns the width (16, 32 or 64).
- R5: In count mode with reverse=0, result is the number of clear bits below the lowest set bit. An all-zero operand returns the width.
- R6: In scan mode with reverse=1 and a nonzero operand, result is the bit index of the highest set bit.
- R7: In scan mode with reverse=0 and a nonzero operand, result is the bit index of the lowest set bit.
- R8: In count mode, flag_def is 2'b11 (bit 0 = carry defined, bit 1 = zero defined). carry_flag is 1 exactly when the extended operand is zero, zero_flag is 1 exactly when result is zero, and no_write is 0.
- R9: In scan mode, flag_def is 2'b10, zero_flag is 1 exactly when the extended operand is zero, and carry_flag is 0.
- R10: In scan mode with an all-zero extended operand, no_write is 1 and result is 0. Otherwise no_write is 0.
- R11: out_valid is 1 exactly one cycle after in_valid is 1. When in_valid is 0, all data outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; inputs are captured when 1 |
| operand | input | 64 | Source operand before zero-extension |
| size_code | input | 2 | Operand width: 0=16, 1=32, 2/3=64 |
| reverse | input | 1 | 1 = search from the top (leading / reverse scan), 0 = from the bottom |
| rep_prefix | input | 1 | Repeat prefix present; requests count mode |
| lead_en | input | 1 | Feature enable for the leading-zero count |
| trail_en | input | 1 | Feature enable for the trailing-zero count |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 7 | Count or bit index |
| carry_flag | output | 1 | Carry flag |
| zero_flag | output | 1 | Zero flag |
| flag_def | output | 2 | Defined flags: bit 0 carry, bit 1 zero |
| no_write | output | 1 | Destination must keep its previous value |

## Verification
Some properties are checked on every cycle. These are the valid timing, the mode chosen from the prefix and enables, and the flag-defined mask. They also cover the tie between zero_flag and result in count mode, the tie between zero_flag and no_write in scan mode, and the zeroed result under no-write. The numeric result depends on where the set bits are, so only the bench can show it is right. The bench also shows that high bits above the width are ignored, that an all-zero operand returns each width, and that outputs hold while idle.

// File: rtl/bitsearch_pkg.sv
package bitsearch_pkg;
    localparam int DATA_W      = 64;
    localparam int MIN_W       = 16;
    localparam int SIZE_CODE_W = 2;
    localparam int CNT_W       = $clog2(DATA_W);
    localparam int RES_W       = CNT_W + 1;

    localparam logic [1:0] FDEF_COUNT = 2'b11;
    localparam logic [1:0] FDEF_SCAN  = 2'b10;

    typedef struct packed {
        logic             valid;
        logic [RES_W-1:0] result;
        logic             carry;
        logic             zero;
        logic [1:0]       fdef;
        logic             nowrite;
    } stage_t;
endpackage

// File: rtl/bs_lead_count.sv
// Leading-zero counter built as a balanced tree in heap order.
// Node k has its high half at 2k+1 and its low half at 2k+2.
// W must be a power of two.
module bs_lead_count #(
    parameter int W = 64,
    parameter int L = $clog2(W)
) (
    input  logic [W-1:0] vec,
    output logic [L:0]   count
);
    localparam int NODES = 2 * W - 1;

    logic [NODES-1:0] hit;
    logic [L-1:0]     pos [NODES];

    // Leaves: the leftmost leaf holds the most significant bit.
    for (genvar j = 0; j < W; j++) begin : g_leaf
        assign hit[W-1+j] = vec[W-1-j];
        assign pos[W-1+j] = '0;
    end

    for (genvar d = 0; d < L; d++) begin : g_depth
        localparam logic [L-1:0] HALF = L'(W >> (d + 1));
        for (genvar j = 0; j < (1 << d); j++) begin : g_node
            localparam int K = (1 << d) - 1 + j;
            assign hit[K] = hit[2*K+1] | hit[2*K+2];
            assign pos[K] = hit[2*K+1] ? pos[2*K+1] : (pos[2*K+2] + HALF);
        end
    end

    assign count = hit[0] ? {1'b0, pos[0]} : (L+1)'(W);
endmodule

// File: rtl/bs_operand_prep.sv
// Zero-extends the operand to the selected width.
// It also builds the variant with every bit above that width forced high.
module bs_operand_prep #(
    parameter int W      = 64,
    parameter int MIN_W  = 16,
    parameter int CODE_W = 2,
    parameter int L      = $clog2(W)
) (
    input  logic [W-1:0]      operand,
    input  logic [CODE_W-1:0] size_code,
    output logic [W-1:0]      ext_op,
    output logic [W-1:0]      filled_op,
    output logic [L:0]        width_val
);
    logic [W-1:0] keep;
    int           wv;

    always_comb begin
        wv = MIN_W << size_code;
        if (wv > W) begin
            wv = W;
        end
        for (int i = 0; i < W; i++) begin
            keep[i] = (i < wv);
        end
        width_val = (L+1)'(wv);
        ext_op    = operand & keep;
        filled_op = ext_op | ~keep;
    end
endmodule

// File: rtl/bitsearch_unit.sv
module bitsearch_unit
    import bitsearch_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [DATA_W-1:0]      operand,
    input  logic [SIZE_CODE_W-1:0] size_code,
    input  logic                   reverse,
    input  logic                   rep_prefix,
    input  logic                   lead_en,
    input  logic                   trail_en,
    output logic                   out_valid,
    output logic [RES_W-1:0]       result,
    output logic                   carry_flag,
    output logic                   zero_flag,
    output logic [1:0]             flag_def,
    output logic                   no_write
);
    logic [DATA_W-1:0] ext_op;
    logic [DATA_W-1:0] filled_op;
    logic [DATA_W-1:0] filled_rev;
    logic [RES_W-1:0]  width_val;
    logic [RES_W-1:0]  lead_cnt;
    logic [RES_W-1:0]  trail_cnt;

    stage_t st_d, st_q;

    bs_operand_prep #(
        .W      (DATA_W),
        .MIN_W  (MIN_W),
        .CODE_W (SIZE_CODE_W),
        .L      (CNT_W)
    ) u_prep (
        .operand   (operand),
        .size_code (size_code),
        .ext_op    (ext_op),
        .filled_op (filled_op),
        .width_val (width_val)
    );

    bs_lead_count #(.W(DATA_W), .L(CNT_W)) u_lead (
        .vec   (ext_op),
        .count (lead_cnt)
    );

    // A trailing count is a leading count of the bit-reversed vector.
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign filled_rev[i] = filled_op[DATA_W-1-i];
    end

    bs_lead_count #(.W(DATA_W), .L(CNT_W)) u_trail (
        .vec   (filled_rev),
        .count (trail_cnt)
    );

    logic             count_mode;
    logic             src_zero;
    logic [RES_W-1:0] lead_adj;
    logic [RES_W-1:0] msb_index;
    logic [RES_W-1:0] res_sel;

    always_comb begin
        count_mode = rep_prefix & (reverse ? lead_en : trail_en);
        src_zero   = ~|ext_op;
        lead_adj   = lead_cnt - (RES_W'(DATA_W) - width_val);
        msb_index  = {1'b0, ~lead_cnt[CNT_W-1:0]};

        if (count_mode) begin
            res_sel = reverse ? lead_adj : trail_cnt;
        end else if (src_zero) begin
            res_sel = '0;
        end else begin
            res_sel = reverse ? msb_index : trail_cnt;
        end

        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result = res_sel;
            if (count_mode) begin
                st_d.carry   = src_zero;
                st_d.zero    = ~|res_sel;
                st_d.fdef    = FDEF_COUNT;
                st_d.nowrite = 1'b0;
            end else begin
                st_d.carry   = 1'b0;
                st_d.zero    = src_zero;
                st_d.fdef    = FDEF_SCAN;
                st_d.nowrite = src_zero;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign result     = st_q.result;
    assign carry_flag = st_q.carry;
    assign zero_flag  = st_q.zero;
    assign flag_def   = st_q.fdef;
    assign no_write   = st_q.nowrite;
endmodule

// File: rtl/bitsearch_unit_chk.sv
module bitsearch_unit_chk
    import bitsearch_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             reverse,
    input logic             rep_prefix,
    input logic             lead_en,
    input logic             trail_en,
    input logic             out_valid,
    input logic [RES_W-1:0] result,
    input logic             carry_flag,
    input logic             zero_flag,
    input logic [1:0]       flag_def,
    input logic             no_write
);
    // R1: reset clears the stage.
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0 && flag_def == 2'b00 && !no_write));

    // R11: valid follows the request by one cycle.
    a_r11_valid_rise: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r11_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(flag_def) && $stable(no_write)));

    // R3: mode choice from prefix and feature enables.
    a_r3_count_sel: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rep_prefix && (reverse ? lead_en : trail_en)) |=> flag_def == FDEF_COUNT);
    a_r3_scan_sel: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !(rep_prefix && (reverse ? lead_en : trail_en))) |=> flag_def == FDEF_SCAN);

    // R8: count-mode flags follow the result.
    a_r8_zero_by_result: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flag_def == FDEF_COUNT) |-> (zero_flag == (result == '0) && !no_write));
    a_r8_carry_nonzero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flag_def == FDEF_COUNT && carry_flag) |-> result != '0);

    // R9: scan-mode flags.
    a_r9_scan_flags: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flag_def == FDEF_SCAN) |-> (!carry_flag && zero_flag == no_write));

    // R10: a suppressed write carries a zero result.
    a_r10_nowrite_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && no_write) |-> (result == '0 && flag_def == FDEF_SCAN));

    // R4: the result never exceeds the full width.
    a_r4_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> result <= RES_W'(DATA_W));
endmodule

bind bitsearch_unit bitsearch_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .reverse    (reverse),
    .rep_prefix (rep_prefix),
    .lead_en    (lead_en),
    .trail_en   (trail_en),
    .out_valid  (out_valid),
    .result     (result),
    .carry_flag (carry_flag),
    .zero_flag  (zero_flag),
    .flag_def   (flag_def),
    .no_write   (no_write)
);

// File: tb/bitsearch_unit_bench.sv
`timescale 1ns/1ps
module bitsearch_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] operand = '0;
    logic [1:0]  size_code = '0;
    logic        reverse = 1'b0;
    logic        rep_prefix = 1'b0;
    logic        lead_en = 1'b0;
    logic        trail_en = 1'b0;
    logic        out_valid;
    logic [6:0]  result;
    logic        carry_flag;
    logic        zero_flag;
    logic [1:0]  flag_def;
    logic        no_write;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bitsearch_unit u_bitsearch_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
        .size_code(size_code), .reverse(reverse), .rep_prefix(rep_prefix),
        .lead_en(lead_en), .trail_en(trail_en), .out_valid(out_valid),
        .result(result), .carry_flag(carry_flag), .zero_flag(zero_flag),
        .flag_def(flag_def), .no_write(no_write)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Returns {result[6:0], carry, zero, fdef[1:0], nowrite}.
    function automatic logic [11:0] model(input logic [63:0] op, input logic [1:0] sc,
                                          input logic rv, input logic rp,
                                          input logic le, input logic te);
        int w;
        logic [63:0] x;
        logic cm;
        logic found;
        int r;
        w = (sc == 2'd0) ? 16 : (sc == 2'd1) ? 32 : 64;
        x = (w == 64) ? op : (op & ((64'd1 << w) - 64'd1));
        cm = rp && (rv ? le : te);
        found = 0;
        r = w;
        if (rv) begin
            for (int i = 63; i >= 0; i--) begin
                if (!found && x[i]) begin found = 1; r = cm ? (w - 1 - i) : i; end
            end
        end else begin
            for (int i = 0; i < 64; i++) begin
                if (!found && x[i]) begin found = 1; r = i; end
            end
        end
        if (cm)
            return {7'(r), (x == 0), (r == 0), 2'b11, 1'b0};
        else if (x == 0)
            return {7'd0, 1'b0, 1'b1, 2'b10, 1'b1};
        else
            return {7'(r), 1'b0, 1'b0, 2'b10, 1'b0};
    endfunction

    task automatic run_op(input logic [63:0] op, input logic [1:0] sc, input logic rv,
                          input logic rp, input logic le, input logic te, input string note);
        logic [11:0] e;
        logic cm;
        string rtag;
        string ftag;
        operand = op; size_code = sc; reverse = rv;
        rep_prefix = rp; lead_en = le; trail_en = te; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        e = model(op, sc, rv, rp, le, te);
        cm = rp && (rv ? le : te);
        if (cm) begin rtag = rv ? "R4" : "R5"; ftag = "R8"; end
        else if (e[0]) begin rtag = "R10"; ftag = "R10"; end
        else begin rtag = rv ? "R6" : "R7"; ftag = "R9"; end
        if (note != "") rtag = {note, "/", rtag};
        chk("R11 out_valid", 32'(out_valid), 32'd1);
        chk({rtag, " result"}, 32'(result), 32'(e[11:5]));
        chk({ftag, " flags"}, 32'({carry_flag, zero_flag, flag_def, no_write}), 32'(e[4:0]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [6:0] held;
        void'($urandom(32'd2468));
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(out_valid), 32'd0);
        chk("R1 result in reset", 32'({result, carry_flag, zero_flag, flag_def, no_write}), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", 32'(out_valid), 32'd0);

        // Zero operand in every mode and width.
        for (int s = 0; s < 3; s++) begin
            run_op(64'd0, 2'(s), 1'b1, 1'b1, 1'b1, 1'b0, "R4 zero");
            run_op(64'd0, 2'(s), 1'b0, 1'b1, 1'b0, 1'b1, "R5 zero");
            run_op(64'd0, 2'(s), 1'b1, 1'b0, 1'b1, 1'b1, "R10");
            run_op(64'd0, 2'(s), 1'b0, 1'b0, 1'b1, 1'b1, "R10");
        end
        // Size code 3 acts as 64 bits.
        run_op(64'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, "R2 code3");
        run_op(64'h8000_0000_0000_0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, "R2 code3");
        // High bits above width ignored.
        run_op(64'hFFFF_FFFF_FFFF_0000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, "R2 high16");
        run_op(64'hFFFF_FFFF_0000_0000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, "R2 high32");
        run_op(64'hABCD_0000_0000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 scan");
        // Boundary bits.
        run_op(64'h0000_0000_0000_8000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R4 top16");
        run_op(64'h0000_0000_0000_0001, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, "R4 bit0");
        run_op(64'h8000_0000_0000_0000, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, "R5 bit63");
        run_op(64'h0000_0000_8000_0000, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, "R6 top32");
        run_op(64'h8000_0000_0000_0001, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R7 both");
        run_op(64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, "R8 zero result");
        // Prefix without the matching enable falls back to scan.
        run_op(64'h0000_0000_0000_0100, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, "R3 no lead_en");
        run_op(64'h0000_0000_0000_0100, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R3 no trail_en");
        run_op(64'h0000_0000_0000_0000, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, "R3 zero fallback");

        // Hold while idle.
        held = result;
        operand = 64'h1; size_code = 2'd2; reverse = 1'b1; rep_prefix = 1'b1; lead_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R11 idle valid", 32'(out_valid), 32'd0);
        chk("R11 idle hold", 32'(result), 32'(held));

        // Random mix.
        for (int n = 0; n < 500; n++) begin
            logic [63:0] r;
            logic [63:0] op;
            logic [3:0] ctl;
            r = {$urandom, $urandom};
            case ($urandom % 5)
                0: op = r;
                1: op = r & (r >> 5) & (r >> 11);
                2: op = 64'd1 << ($urandom % 64);
                3: op = r >> ($urandom % 64);
                default: op = r << ($urandom % 64);
            endcase
            ctl = 4'($urandom);
            run_op(op, 2'($urandom), ctl[0], ctl[1], ctl[2], ctl[3], "");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule